// File: doc/BRIEF.md
# Two-Phase Divide-by-Four Cascade Baud Clock Generator

This block turns a single fast reference clock into slower timing for a serial shift register. With the expected 1.8432 MHz reference, the output rate is 115200 baud. The design uses a chain of divide-by-four cells. Each cell holds a two-bit state that steps in Gray order: 00, 01, 11, 10. Every cell produces two phase strobes. The first phase marks entry into state 01 and the second marks entry into state 10. These two states are opposite each other in the cycle, so the strobes of one cell can never overlap.

The first cell steps on every reference cycle. Each later cell steps only when the cell before it emits its second phase. Each added cell therefore multiplies the division ratio by four. The second phase of the last cell drives the pass stages of the shift register. The first phase of the last cell is also brought out as the baud tick.

All outputs are one-cycle enables in the reference clock domain, not separate clocks. There is no data stream, so the block has no valid/ready handshake. Every pin is a plain control pin. The number of cells is a parameter, and two cells give the divide-by-16 needed for the baud rate.

Top module: `baud_phase_gen`

## Requirements
- R1: A synchronous, active-high `rst` clears every cell to state 00. In the cycle after any clock edge that sees `rst` high, every bit of `phi1_o` and `phi2_o` is low and `baud_tick_o` is low.
- R2: Count the clock edges after reset is released, with the first edge at which `rst` is low as edge 1. After edge n, `phi1_o[0]` is high for exactly one cycle when n mod 4 = 1, and low otherwise.
- R3: `phi2_o[0]` is high for one cycle when n mod 4 = 3, which is two cycles after each first-cell first phase. It is low otherwise.
- R4: For each cell k, `phi1_o[k]` and `phi2_o[k]` are never high in the same cycle. Within a cell, first and second phases strictly alternate, and the first phase comes first.
- R5: Cell k (k ≥ 1) advances only on a `phi2_o[k-1]` pulse. Any phase of cell k goes high only in the cycle right after `phi2_o[k-1]` was high. With two cells, `phi1_o[1]` is high when n mod 16 = 4.
- R6: The second phase of cell k follows its first phase by 2·4^k cycles. With two cells, `phi2_o[1]` is high when n mod 16 = 12.
- R7: `baud_tick_o` is a one-cycle pulse that coincides with the last cell's first phase. Consecutive ticks are exactly 4^STAGES cycles apart, which is 16 with the default of two cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every rising edge is one input event for the first cell |
| rst | input | 1 | Synchronous active-high reset to state 00 in all cells |
| phi1_o | output | STAGES | Per-cell first phase strobe, on entry to state 01 |
| phi2_o | output | STAGES | Per-cell second phase strobe, on entry to state 10 |
| baud_tick_o | output | 1 | One pulse per 4^STAGES reference cycles |

## Verification
The bench builds the block with the default of two cells. This makes a full baud period 16 cycles long, so three whole periods and a restart after a mid-run reset fit in a short run. Each cycle is compared against a 16-entry expected pattern for all five outputs. That exposes any slip in the Gray order, in the cascade condition or in the phase decode as a wrong cycle on a specific output. Tick-to-tick spacing and same-cell phase exclusivity are measured separately. This confirms both the divide-by-16 ratio and the non-overlap rule.

// File: rtl/baud_phase_pkg.sv
package baud_phase_pkg;

  // Two-bit Gray sequence of one divide-by-four cell; codes are behavioural:
  // the phase decode keys on the lead (01) and trail (10) codes.
  typedef enum logic [1:0] {
    GS_IDLE  = 2'b00,
    GS_LEAD  = 2'b01,
    GS_HOLD  = 2'b11,
    GS_TRAIL = 2'b10
  } gray_state_t;

  function automatic gray_state_t gray_step(input gray_state_t cur);
    gray_state_t nxt;
    case (cur)
      GS_IDLE:  nxt = GS_LEAD;
      GS_LEAD:  nxt = GS_HOLD;
      GS_HOLD:  nxt = GS_TRAIL;
      default:  nxt = GS_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/gray_div4_cell.sv
module gray_div4_cell
  import baud_phase_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output gray_state_t state_nxt
);

  gray_state_t state_q;

  always_comb begin
    state_nxt = adv ? gray_step(state_q) : state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GS_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

endmodule

// File: rtl/phase_pulse_decode.sv
module phase_pulse_decode
  import baud_phase_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  input  gray_state_t state_nxt,
  output logic        phi1_q,
  output logic        phi2_q
);

  // Registered decode: a strobe lasts only the cycle in which the cell
  // enters the lead or trail code, whatever the cell's dwell time.
  always_ff @(posedge clk) begin
    if (rst) begin
      phi1_q <= 1'b0;
      phi2_q <= 1'b0;
    end else begin
      phi1_q <= adv && (state_nxt == GS_LEAD);
      phi2_q <= adv && (state_nxt == GS_TRAIL);
    end
  end

endmodule

// File: rtl/baud_phase_gen.sv
module baud_phase_gen
  import baud_phase_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STAGES-1:0] phi1_o,
  output logic [STAGES-1:0] phi2_o,
  output logic              baud_tick_o
);

  logic [STAGES-1:0] adv_w;

  for (genvar g = 0; g < STAGES; g++) begin : g_cell
    gray_state_t nxt_w;

    if (g == 0) begin : g_head
      assign adv_w[g] = 1'b1;
    end else begin : g_tail
      assign adv_w[g] = phi2_o[g-1];
    end

    gray_div4_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .adv       (adv_w[g]),
      .state_nxt (nxt_w)
    );

    phase_pulse_decode u_dec (
      .clk       (clk),
      .rst       (rst),
      .adv       (adv_w[g]),
      .state_nxt (nxt_w),
      .phi1_q    (phi1_o[g]),
      .phi2_q    (phi2_o[g])
    );
  end

  assign baud_tick_o = phi1_o[STAGES-1];

endmodule

// File: rtl/baud_phase_chk.sv
module baud_phase_chk #(
  parameter int STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [STAGES-1:0] phi1_o,
  input logic [STAGES-1:0] phi2_o,
  input logic              baud_tick_o
);

  localparam int DIVIDE = 4 ** STAGES;
  localparam int GW     = $clog2(DIVIDE) + 2;

  logic [GW-1:0]     gap_q;
  logic              seen_q;
  logic [STAGES-1:0] lead_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q       <= '0;
      seen_q      <= 1'b0;
      lead_last_q <= '0;
    end else begin
      if (baud_tick_o) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q <= GW'(DIVIDE)) begin
        gap_q <= gap_q + GW'(1);
      end
      for (int k = 0; k < STAGES; k++) begin
        if (phi1_o[k]) lead_last_q[k] <= 1'b1;
        else if (phi2_o[k]) lead_last_q[k] <= 1'b0;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phi1_o == '0 && phi2_o == '0 && !baud_tick_o)); // R1

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (seen_q && baud_tick_o) |-> (gap_q == GW'(DIVIDE))); // R7

  AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
    (seen_q && gap_q == GW'(DIVIDE)) |-> baud_tick_o); // R7

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(phi1_o[k] && phi2_o[k])); // R4

    AST_LEAD_ALT: assert property (@(posedge clk) disable iff (rst)
      phi1_o[k] |-> !lead_last_q[k]); // R4

    AST_TRAIL_ALT: assert property (@(posedge clk) disable iff (rst)
      phi2_o[k] |-> lead_last_q[k]); // R4

    if (k > 0) begin : g_casc
      AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (rst)
        (phi1_o[k] || phi2_o[k]) |-> $past(phi2_o[k-1])); // R5
    end
  end

endmodule

bind baud_phase_gen baud_phase_chk #(.STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phi1_o      (phi1_o),
  .phi2_o      (phi2_o),
  .baud_tick_o (baud_tick_o)
);

// File: tb/baud_phase_gen_tb.sv
module baud_phase_gen_tb;

  localparam int STAGES = 2;
  localparam int PERIOD = 16;

  // Bits: {tick, phi2[1], phi1[1], phi2[0], phi1[0]}, indexed by n mod 16
  localparam logic [4:0] EXP [16] = '{
    5'b00000, 5'b00001, 5'b00000, 5'b00010,
    5'b10100, 5'b00001, 5'b00000, 5'b00010,
    5'b00000, 5'b00001, 5'b00000, 5'b00010,
    5'b01000, 5'b00001, 5'b00000, 5'b00010
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [STAGES-1:0] phi1_o;
  logic [STAGES-1:0] phi2_o;
  logic              baud_tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  baud_phase_gen #(.STAGES(STAGES)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .phi1_o      (phi1_o),
    .phi2_o      (phi2_o),
    .baud_tick_o (baud_tick_o)
  );

  task automatic check_val(input string tag, input int n, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic check_cycle(input int n);
    logic [4:0] e;
    e = EXP[n % PERIOD];
    check_val("R2", n, int'(phi1_o[0]), int'(e[0]));
    check_val("R3", n, int'(phi2_o[0]), int'(e[1]));
    check_val("R5", n, int'(phi1_o[1]), int'(e[2]));
    check_val("R6", n, int'(phi2_o[1]), int'(e[3]));
    check_val("R7", n, int'(baud_tick_o), int'(e[4]));
    check_val("R4", n, int'((phi1_o & phi2_o) != '0), 0);
  endtask

  task automatic check_quiet(input int n);
    check_val("R1", n, int'({phi1_o, phi2_o, baud_tick_o}), 0);
  endtask

  initial begin
    int last_tick;
    int tick_gaps;
    last_tick = -1;
    tick_gaps = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_quiet(0);
    rst = 1'b0;

    for (int n = 1; n <= 3 * PERIOD; n++) begin
      @(negedge clk);
      check_cycle(n);
      if (baud_tick_o) begin
        if (last_tick >= 0) begin
          check_val("R7", n, n - last_tick, PERIOD);
          tick_gaps++;
        end
        last_tick = n;
      end
    end
    check_val("R7", 0, tick_gaps, 2);

    // Mid-period reset: land on a cycle where stage 1 is mid-count
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_quiet(1);
    @(negedge clk);
    check_quiet(2);
    rst = 1'b0;

    for (int n = 1; n <= PERIOD + 1; n++) begin
      @(negedge clk);
      check_cycle(n);
    end

    // One-cycle reset pulse right on a tick cycle
    while (!baud_tick_o) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_quiet(3);
    rst = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      check_cycle(n);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule